// File: doc/BRIEF.md
# Prescaled Timer with Dual Compare

This block is an 8-bit up-counter timer with two compare channels and overflow detection. A 3-bit clock-select field chooses what advances the counter. The counter can be stopped, or it can count the system clock through a shared free-running prescaler at divide-by 1, 8, 64, 256 or 1024. It can also count edges on an external pin, rising or falling. A small synchronous register port reads and writes the counter, the two compare values, the interrupt enables, the sticky event flags and the clock-select field.

Every count tick compares the counter with each compare value. A hit pulses that channel's match output for one cycle and sets its flag. Wrapping from 255 to 0 sets the overflow flag. The interrupt request is the OR of every flag that is enabled. When software writes the counter, the compare on the next tick is suppressed, so loading the counter with a compare value does not raise a match.

Top module: `tmr8_dualcmp`

## Requirements
- R1: The register addresses are 0 counter, 1 compare A, 2 compare B, 3 interrupt enable, 4 flags and 5 control, with the clock select in bits 2:0. Other addresses read as 0. After reset every register reads 0, and `irq` and both match pulses are low.
- R2: With clock-select code 000 the counter holds its value.
- R3: Code 001 advances the counter on every clock cycle. Codes 010, 011, 100 and 101 advance it once per 8, 64, 256 and 1024 cycles of a shared prescaler.
- R4: Code 111 advances the counter once per rising edge of `ext_cnt_pin`, and code 110 once per falling edge. The opposite edge has no effect. The pin passes through a two-flop synchronizer, so a count appears at most 4 cycles after the pin changes.
- R5: A write to the counter is readable in the next cycle. If a count tick arrives in the same cycle, the written value wins.
- R6: When a tick occurs while the counter equals a compare value, that channel's match output is high for exactly one cycle. In the same cycle its flag bit is set: bit 1 for A, bit 2 for B.
- R7: A write to the counter suppresses both compare matches on the first tick after it. Later ticks compare normally.
- R8: A tick at count 255 wraps the counter to 0 and sets flag bit 0 (overflow).
- R9: Flag bits are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: The interrupt enable register holds overflow in bit 0, A in bit 1 and B in bit 2, and its bits 7:3 read 0. `irq` is high when any flag bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_cnt_pin | input | 1 | External count input |
| match_a | output | 1 | One-cycle pulse on a compare A match |
| match_b | output | 1 | One-cycle pulse on a compare B match |
| irq | output | 1 | Enabled-flag interrupt request |

## Verification
The counting function is tested in three ways:
- **Stopped source:** a window with no count source shows that the counter holds.
- **Divided clock:** an exact-start run at divide-by-1 fixes the latency. Measured windows of a multiple of each divisor separate 8, 64, 256 and 1024 from one another.
- **External pin:** pulse trains on the pin under both edge codes show that only the selected edge counts, once per edge.

Compare behaviour is tested with a free-running approach to two distinct compare values, which fixes the cycle of each pulse. A counter load equal to compare A separates the suppressed tick from the normal compare on the tick after it, using compare B. A load of 254 reaches the wrap, and flag writes of 0 and 1 separate sticky from cleared.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT  = 3'd0,
    A_CMPA = 3'd1,
    A_CMPB = 3'd2,
    A_MASK = 3'd3,
    A_FLAG = 3'd4,
    A_CTRL = 3'd5
  } addr_e;

  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } csel_e;
endpackage

// File: rtl/tmr8_tick_gen.sv
module tmr8_tick_gen
  import tmr8_pkg::*;
#(
  parameter int unsigned PRE_W = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  csel_e sel,
  input  logic  ext_pin,
  output logic  tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [2:0]       sync_q, sync_d;
  logic             ext_rise, ext_fall;

  always_comb begin
    pre_d  = pre_q + 1'b1;
    sync_d = {sync_q[1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_d;
      sync_q <= sync_d;
    end
  end

  // sync_q[1] is the synchronized pin, sync_q[2] its previous value
  always_comb begin
    ext_rise = sync_q[1] & ~sync_q[2];
    ext_fall = ~sync_q[1] & sync_q[2];
  end

  always_comb begin
    unique case (sel)
      CS_OFF:      tick = 1'b0;
      CS_DIV1:     tick = 1'b1;
      CS_DIV8:     tick = &pre_q[2:0];
      CS_DIV64:    tick = &pre_q[5:0];
      CS_DIV256:   tick = &pre_q[7:0];
      CS_DIV1024:  tick = &pre_q[PRE_W-1:0];
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = 1'b0;
    endcase
  end

  // R4: one count per edge, never on two cycles in a row
  a_r4_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == CS_EXT_RISE && $stable(sel)) |=> !(tick && sel == CS_EXT_RISE));
endmodule

// File: rtl/tmr8_count_cmp.sv
module tmr8_count_cmp #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned NUM_CMP = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          cnt_we,
  input  logic [CNT_W-1:0]              cnt_wdata,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val,
  input  logic [NUM_CMP:0]              flag_clr,
  output logic [CNT_W-1:0]              cnt,
  output logic [NUM_CMP:0]              flags,
  output logic [NUM_CMP-1:0]            match
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               blk_q, blk_d;
  logic [NUM_CMP:0]   flags_q, flags_d, evt;
  logic [NUM_CMP-1:0] match_q;
  logic               adv;

  always_comb begin
    adv   = tick && !cnt_we;
    cnt_d = cnt_q;
    blk_d = blk_q;
    if (cnt_we) begin
      cnt_d = cnt_wdata;
      blk_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      blk_d = 1'b0;
    end
  end

  assign evt[0] = adv && (cnt_q == {CNT_W{1'b1}});

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign evt[i+1] = adv && !blk_q && (cnt_q == cmp_val[i]);

    // R6: a match pulse always comes with its flag
    a_r6_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
      match_q[i] |-> flags_q[i+1]);
  end

  always_comb flags_d = (flags_q & ~flag_clr) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blk_q   <= 1'b0;
      flags_q <= '0;
      match_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      blk_q   <= blk_d;
      flags_q <= flags_d;
      match_q <= evt[NUM_CMP:1];
    end
  end

  assign cnt   = cnt_q;
  assign flags = flags_q;
  assign match = match_q;

  // R2: without tick or write the counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt_q));
  // R5: a write lands regardless of a tick
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));
  // R7: the first tick after a write raises no match
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk_q && !cnt_we) |=> match_q == '0);
  // R8: wrap to zero sets overflow
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0 && flags_q[0]));
endmodule

// File: rtl/tmr8_dualcmp.sv
module tmr8_dualcmp
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_cnt_pin,
  output logic              match_a,
  output logic              match_b,
  output logic              irq
);
  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned FLG_W   = NUM_CMP + 1;

  logic [1:0]                   rsync_q;
  logic                         rst_int_n;
  csel_e                        ctrl_q, ctrl_d;
  logic [FLG_W-1:0]             mask_q, mask_d;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic                         tick, cnt_we;
  logic [FLG_W-1:0]             flag_clr, flags;
  logic [CNT_W-1:0]             cnt;
  logic [NUM_CMP-1:0]           match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_comb begin
    ctrl_d   = ctrl_q;
    mask_d   = mask_q;
    cmp_d    = cmp_q;
    cnt_we   = 1'b0;
    flag_clr = '0;
    if (bus_we) begin
      unique case (bus_addr)
        A_CNT:   cnt_we    = 1'b1;
        A_CMPA:  cmp_d[0]  = bus_wdata;
        A_CMPB:  cmp_d[1]  = bus_wdata;
        A_MASK:  mask_d    = bus_wdata[FLG_W-1:0];
        A_FLAG:  flag_clr  = bus_wdata[FLG_W-1:0];
        A_CTRL:  ctrl_d    = csel_e'(bus_wdata[2:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= CS_OFF;
      mask_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      cmp_q  <= cmp_d;
    end
  end

  tmr8_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel     (ctrl_q),
    .ext_pin (ext_cnt_pin),
    .tick    (tick)
  );

  tmr8_count_cmp #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .cnt_we    (cnt_we),
    .cnt_wdata (bus_wdata),
    .cmp_val   (cmp_q),
    .flag_clr  (flag_clr),
    .cnt       (cnt),
    .flags     (flags),
    .match     (match)
  );

  always_comb begin
    unique case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_CMPA:  bus_rdata = cmp_q[0];
      A_CMPB:  bus_rdata = cmp_q[1];
      A_MASK:  bus_rdata = {{(CNT_W-FLG_W){1'b0}}, mask_q};
      A_FLAG:  bus_rdata = {{(CNT_W-FLG_W){1'b0}}, flags};
      A_CTRL:  bus_rdata = {{(CNT_W-3){1'b0}}, ctrl_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = |(flags & mask_q);
  assign match_a = match[0];
  assign match_b = match[1];

  // R10: a request needs at least one enable set
  a_r10_irq_enabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (mask_q != '0 && flags != '0));
endmodule

// File: tb/tmr8_dualcmp_bench.sv
module tmr8_dualcmp_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ext_cnt_pin;
  logic       match_a, match_b, irq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  tmr8_dualcmp u_tmr8_dualcmp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_cnt_pin(ext_cnt_pin),
    .match_a(match_a), .match_b(match_b), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", irq, 0);
    chk("R1 reset match", {match_a, match_b}, 0);
  endtask

  task automatic t_stop();
    logic [7:0] v0, v1;
    wr(3'd0, 8'd77);
    rd(3'd0, v0);
    repeat (50) @(negedge clk);
    rd(3'd0, v1);
    chk("R2 stopped hold", v1, 77);
  endtask

  task automatic t_div();
    logic [7:0] v0, v1;
    int div [4] = '{8, 64, 256, 1024};
    wr(3'd0, 8'd0);
    wr(3'd5, 8'd1);
    rd(3'd0, v0);
    chk("R3 div1 start", v0, 0);
    repeat (5) @(negedge clk);
    rd(3'd0, v1);
    chk("R3 div1 count", v1, 5);
    for (int k = 0; k < 4; k++) begin
      wr(3'd5, 8'(k + 2));
      rd(3'd0, v0);
      repeat (2 * div[k]) @(negedge clk);
      rd(3'd0, v1);
      chk($sformatf("R3 div%0d delta", div[k]), 8'(v1 - v0), 2);
    end
    wr(3'd5, 8'd0);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr(3'd5, 8'd7);
    wr(3'd0, 8'd0);
    for (int p = 0; p < 3; p++) begin
      ext_cnt_pin = 1'b1; repeat (5) @(negedge clk);
      ext_cnt_pin = 1'b0; repeat (5) @(negedge clk);
    end
    rd(3'd0, v);
    chk("R4 rising edges", v, 3);
    wr(3'd5, 8'd6);
    wr(3'd0, 8'd0);
    ext_cnt_pin = 1'b1; repeat (5) @(negedge clk);
    rd(3'd0, v);
    chk("R4 rise ignored in fall mode", v, 0);
    ext_cnt_pin = 1'b0; repeat (5) @(negedge clk);
    ext_cnt_pin = 1'b1; repeat (5) @(negedge clk);
    ext_cnt_pin = 1'b0; repeat (5) @(negedge clk);
    rd(3'd0, v);
    chk("R4 falling edges", v, 2);
    wr(3'd5, 8'd0);
  endtask

  task automatic t_write_wins();
    logic [7:0] v;
    wr(3'd5, 8'd1);
    wr(3'd0, 8'd50);
    rd(3'd0, v);
    chk("R5 write wins over tick", v, 50);
    wr(3'd5, 8'd0);
  endtask

  task automatic t_match();
    logic [7:0] v;
    int first_a = 0, first_b = 0, na = 0, nb = 0;
    wr(3'd4, 8'h07);
    wr(3'd1, 8'd10);
    wr(3'd2, 8'd12);
    wr(3'd0, 8'd8);
    wr(3'd5, 8'd1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (match_a) begin na++; if (first_a == 0) first_a = k; end
      if (match_b) begin nb++; if (first_b == 0) first_b = k; end
    end
    wr(3'd5, 8'd0);
    chk("R6 match A cycle", first_a, 3);
    chk("R6 match A width", na, 1);
    chk("R6 match B cycle", first_b, 5);
    chk("R6 match B width", nb, 1);
    rd(3'd4, v);
    chk("R6 flags A and B", v & 8'h06, 6);
  endtask

  task automatic t_block();
    logic [7:0] v;
    int na = 0, first_b = 0;
    wr(3'd4, 8'h07);
    wr(3'd1, 8'd20);
    wr(3'd2, 8'd21);
    wr(3'd0, 8'd20);
    wr(3'd5, 8'd1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (match_a) na++;
      if (match_b && first_b == 0) first_b = k;
    end
    wr(3'd5, 8'd0);
    chk("R7 blocked match A", na, 0);
    chk("R7 next tick compares B", first_b, 2);
    rd(3'd4, v);
    chk("R7 flag A clear", v & 8'h02, 0);
  endtask

  task automatic t_ovf_irq();
    logic [7:0] v;
    wr(3'd4, 8'h07);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'd254);
    wr(3'd5, 8'd1);
    repeat (2) @(negedge clk);
    rd(3'd0, v);
    chk("R8 wrap to zero", v, 0);
    rd(3'd4, v);
    chk("R8 overflow flag", v, 1);
    wr(3'd5, 8'd0);
    chk("R10 irq masked", irq, 0);
    wr(3'd3, 8'hFF);
    rd(3'd3, v);
    chk("R10 mask upper bits", v, 7);
    chk("R10 irq enabled", irq, 1);
    wr(3'd4, 8'h00);
    rd(3'd4, v);
    chk("R9 write 0 keeps flag", v, 1);
    wr(3'd4, 8'h06);
    rd(3'd4, v);
    chk("R9 other bits keep flag", v, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, v);
    chk("R9 write 1 clears", v, 0);
    chk("R10 irq drops", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; ext_cnt_pin = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stop();
    t_div();
    t_ext();
    t_write_wins();
    t_match();
    t_block();
    t_ovf_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule